// File: doc/BRIEF.md
# Spare-Area Status Byte Stripper

This block sits on the byte stream that carries the spare (out-of-band) area of a page after the correction engine has processed it. In that stream, each chunk's spare bytes are followed by a gap of four status bytes. The stripper removes every gap, so the spare data leaves as one linear run of bytes. The first byte of each gap is this chunk's correction status. The block reports it together with the chunk number on a one-cycle strobe. The other three gap bytes are discarded.

Software or a sequencer sets the per-chunk spare size and the chunk count. The per-chunk spare size is the whole spare area divided by the number of chunks. It then pulses `start`, which captures both values, and streams the bytes through. Input and output use a valid/ready handshake. Once the last chunk's gap has been consumed, `done` pulses and the block goes back to idle. A configuration with a zero size or a zero count is refused.

Top module: `spare_stat_strip`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `stat_valid`, `done` and `err` are all 0.
- R2: A `start` pulse in idle with nonzero `cfg_spare_sz` (S) and `cfg_chunks` (N) captures both values, keeps `err` at 0 and begins a transfer of N*(S+4) input bytes.
- R3: Input byte i is forwarded when i mod (S+4) < S. The k-th forwarded byte therefore equals input byte (k/S)*(S+4) + k mod S, and the output has no gaps.
- R4: For chunk n, the input byte at offset S + n*(S+4) appears on `stat_byte`, with `stat_idx` = n. `stat_valid` is high for exactly one cycle, in the cycle after that byte is accepted.
- R5: The three bytes at offsets S+1..S+3 of each gap are neither forwarded nor reported. `out_valid` stays 0 and `stat_valid` stays 0 for them.
- R6: While the current position is a data byte, `in_ready` equals `out_ready`. While it is a gap byte, `in_ready` is 1 whatever the value of `out_ready`.
- R7: `done` is high for one cycle, in the cycle after the last gap byte of chunk N-1 is accepted. From that cycle on, `in_ready` is 0 until the next accepted `start`.
- R8: A `start` in idle with S = 0 or N = 0 sets `err` and leaves `in_ready` at 0. A later `start` with nonzero values clears `err`.
- R9: A `start` pulse during a transfer is ignored. The transfer continues with the values captured when it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (honoured only in idle) |
| cfg_spare_sz | input | SPARE_W | Spare bytes per chunk |
| cfg_chunks | input | CNT_W | Number of chunks |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_valid | output | 1 | Forwarded spare byte valid |
| out_data | output | 8 | Forwarded spare byte |
| out_ready | input | 1 | Downstream accepts the forwarded byte |
| stat_valid | output | 1 | One-cycle status capture strobe |
| stat_byte | output | 8 | Captured status byte |
| stat_idx | output | CNT_W | Chunk number of the captured status |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last start was refused (zero size or count) |

## Verification
If the byte position inside a chunk drifts, the error shows within one chunk. A data byte is either dropped or taken from a gap, so the forwarded byte no longer matches the gap-skipping index formula. `stat_byte` also takes the wrong offset within the same S+4 bytes. If the chunk counter is wrong, `stat_idx` shows it at the next status strobe, and `done` comes one chunk early or late. The sweep covers every size from 1 to 6 and every count from 1 to 4. It runs each of these under three downstream ready patterns and randomly gapped input, so a stall-related fault appears as a lost or repeated output byte.

// File: rtl/sss_pkg.sv
// Shared definitions for the spare-area status byte stripper.
// Assumes every chunk's spare run is followed by a fixed-size status gap.
package sss_pkg;
    // number of inserted status bytes after each chunk's spare run
    localparam int GAP_LEN = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sss_seq.sv
// Position sequencer: tracks the byte offset inside the current chunk
// (spare run followed by the status gap) and the chunk number. It also
// captures the configuration at start and raises err or done.
// Assumes byte_acc is high only while running and a byte is taken.
module sss_seq
    import sss_pkg::*;
#(
    parameter int SPARE_W = 8,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SPARE_W-1:0] cfg_spare_sz,
    input  logic [CNT_W-1:0]   cfg_chunks,
    input  logic               byte_acc,
    output logic               running,
    output logic               data_phase,
    output logic               first_gap,
    output logic [CNT_W-1:0]   chunk_idx,
    output logic               err,
    output logic               done
);
    localparam int POS_W = SPARE_W + 1;

    seq_state_e         state_q;
    logic [SPARE_W-1:0] spare_q;
    logic [CNT_W-1:0]   chunks_q;
    logic [POS_W-1:0]   pos_q;
    logic [CNT_W-1:0]   chunk_q;
    logic               err_q;
    logic               done_q;

    logic [POS_W-1:0]   spare_ext;
    logic [POS_W-1:0]   gap_end;
    logic               last_gap;
    logic               last_chunk;
    logic               cfg_bad;

    // decode where the current position falls inside the chunk
    always_comb begin
        spare_ext  = {1'b0, spare_q};
        gap_end    = spare_ext + POS_W'(GAP_LEN - 1);
        data_phase = pos_q < spare_ext;
        first_gap  = pos_q == spare_ext;
        last_gap   = pos_q == gap_end;
        last_chunk = chunk_q == (chunks_q - CNT_W'(1));
        cfg_bad    = (cfg_spare_sz == '0) || (cfg_chunks == '0);
    end

    // state, configuration capture, counters and end-of-transfer pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            spare_q  <= '0;
            chunks_q <= '0;
            pos_q    <= '0;
            chunk_q  <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        err_q <= cfg_bad;
                        if (!cfg_bad) begin
                            spare_q  <= cfg_spare_sz;
                            chunks_q <= cfg_chunks;
                            pos_q    <= '0;
                            chunk_q  <= '0;
                            state_q  <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (byte_acc) begin
                        if (last_gap) begin
                            pos_q <= '0;
                            if (last_chunk) begin
                                done_q  <= 1'b1;
                                state_q <= SEQ_IDLE;
                            end else begin
                                chunk_q <= chunk_q + CNT_W'(1);
                            end
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign running   = state_q == SEQ_RUN;
    assign chunk_idx = chunk_q;
    assign err       = err_q;
    assign done      = done_q;
endmodule

// File: rtl/sss_steer.sv
// Handshake steering: in a data position the byte passes straight through
// and waits for the downstream; in a gap position it is always taken.
// Assumes running, data_phase come from the sequencer for the current byte.
module sss_steer (
    input  logic running,
    input  logic data_phase,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic byte_acc
);
    // route ready and valid according to the byte's position
    always_comb begin
        out_valid = running && data_phase && in_valid;
        in_ready  = running && (data_phase ? out_ready : 1'b1);
        byte_acc  = in_valid && in_ready;
    end
endmodule

// File: rtl/sss_stat_cap.sv
// Status capture: registers the first gap byte of each chunk with its chunk
// number and raises a one-cycle strobe in the following cycle.
// Assumes take is high for exactly one accepted byte per chunk.
module sss_stat_cap #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [7:0]       byte_in,
    input  logic [CNT_W-1:0] idx_in,
    output logic             stat_valid,
    output logic [7:0]       stat_byte,
    output logic [CNT_W-1:0] stat_idx
);
    // hold the last captured status and pulse the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_byte  <= '0;
            stat_idx   <= '0;
        end else begin
            stat_valid <= take;
            if (take) begin
                stat_byte <= byte_in;
                stat_idx  <= idx_in;
            end
        end
    end
endmodule

// File: rtl/spare_stat_strip.sv
// Top of the spare-area status byte stripper. It removes the status gap after
// each chunk of the incoming spare stream, forwards the spare bytes without
// gaps and reports the first gap byte of each chunk.
// Assumes cfg_* are stable while start is high.
module spare_stat_strip #(
    parameter int SPARE_W = 8,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SPARE_W-1:0] cfg_spare_sz,
    input  logic [CNT_W-1:0]   cfg_chunks,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               stat_valid,
    output logic [7:0]         stat_byte,
    output logic [CNT_W-1:0]   stat_idx,
    output logic               done,
    output logic               err
);
    logic             running;
    logic             data_phase;
    logic             first_gap;
    logic             byte_acc;
    logic [CNT_W-1:0] chunk_idx;

    sss_seq #(
        .SPARE_W (SPARE_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_spare_sz (cfg_spare_sz),
        .cfg_chunks   (cfg_chunks),
        .byte_acc     (byte_acc),
        .running      (running),
        .data_phase   (data_phase),
        .first_gap    (first_gap),
        .chunk_idx    (chunk_idx),
        .err          (err),
        .done         (done)
    );

    sss_steer u_steer (
        .running    (running),
        .data_phase (data_phase),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .byte_acc   (byte_acc)
    );

    sss_stat_cap #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (byte_acc && first_gap),
        .byte_in    (in_data),
        .idx_in     (chunk_idx),
        .stat_valid (stat_valid),
        .stat_byte  (stat_byte),
        .stat_idx   (stat_idx)
    );

    // data bytes pass through unchanged
    assign out_data = in_data;
endmodule

// File: rtl/sss_chk.sv
// Checker for the stripper's port-level timing rules, bound to the top.
module sss_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic stat_valid,
    input logic done,
    input logic err
);
    // R3
    fwd_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_valid && (in_ready == out_ready)));

    // R4
    stat_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    // R6
    stall_holds_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_ready && !out_valid));

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready);
endmodule

bind spare_stat_strip sss_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .stat_valid (stat_valid),
    .done       (done),
    .err        (err)
);

// File: tb/spare_stat_strip_tb.sv
// Sweep bench: sizes 1..6, counts 1..4, three downstream ready patterns.
module spare_stat_strip_tb;
    localparam int SPARE_W = 8;
    localparam int CNT_W   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [SPARE_W-1:0] cfg_spare_sz = '0;
    logic [CNT_W-1:0]   cfg_chunks = '0;
    logic               in_valid = 1'b0;
    logic [7:0]         in_data = '0;
    logic               in_ready;
    logic               out_valid;
    logic [7:0]         out_data;
    logic               out_ready = 1'b0;
    logic               stat_valid;
    logic [7:0]         stat_byte;
    logic [CNT_W-1:0]   stat_idx;
    logic               done;
    logic               err;

    int total = 0;
    int bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    spare_stat_strip #(.SPARE_W(SPARE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_spare_sz(cfg_spare_sz),
        .cfg_chunks(cfg_chunks), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .stat_valid(stat_valid), .stat_byte(stat_byte),
        .stat_idx(stat_idx), .done(done), .err(err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // one complete transfer; glitch pulses start mid-transfer (R9)
    task automatic run_xfer(input int s, input int n, input int mode, input int seed,
                            input bit glitch);
        int i = 0;
        int k = 0;
        int tot = n * (s + 4);
        bit pend_stat = 0;
        bit pend_done = 0;
        int stat_i = 0;
        bit fin = 0;
        bit did = 0;
        int guard = 0;
        @(negedge clk);
        cfg_spare_sz = SPARE_W'(s);
        cfg_chunks = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        // R2
        chk(err == 1'b0, "R2 err after start", int'(err), 0);
        while (!fin && guard < 2000) begin
            if (guard > 0) @(negedge clk);
            guard++;
            step_lfsr();
            start = 1'b0;
            cfg_spare_sz = SPARE_W'(s);
            if (glitch && !did && i == 2) begin
                start = 1'b1;
                cfg_spare_sz = SPARE_W'(s + 1);
                did = 1;
            end
            in_valid = pend_done ? 1'b1 : lfsr[0] | lfsr[3];
            in_data = pat(i, seed);
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = guard[0];
                default: out_ready = lfsr[5];
            endcase
            #1;
            // status strobe for the byte taken at the previous edge
            if (pend_stat) begin
                // R4
                chk(stat_valid == 1'b1, "R4 stat_valid", int'(stat_valid), 1);
                chk(stat_byte == pat(stat_i, seed), "R4 stat_byte", int'(stat_byte),
                    int'(pat(stat_i, seed)));
                chk(int'(stat_idx) == stat_i / (s + 4), "R4 stat_idx", int'(stat_idx),
                    stat_i / (s + 4));
            end else begin
                // R5
                chk(stat_valid == 1'b0, "R5 no stray stat", int'(stat_valid), 0);
            end
            // R7
            chk(done == pend_done, "R7 done timing", int'(done), int'(pend_done));
            if (pend_done) begin
                // R7
                chk(in_ready == 1'b0, "R7 idle after done", int'(in_ready), 0);
                chk(k == n * s, "R3 forwarded count", k, n * s);
                fin = 1;
            end else begin
                int p = i % (s + 4);
                bit acc;
                if (in_valid) begin
                    // R6
                    chk(in_ready == ((p < s) ? out_ready : 1'b1), "R6 in_ready",
                        int'(in_ready), int'((p < s) ? out_ready : 1'b1));
                end
                // R3 R5
                chk(out_valid == (in_valid && p < s), "R3 R5 out_valid",
                    int'(out_valid), int'(in_valid && p < s));
                acc = in_valid && in_ready;
                pend_stat = acc && (p == s);
                pend_done = acc && (i == tot - 1);
                if (acc) begin
                    if (p < s) begin
                        int src = (k / s) * (s + 4) + (k % s);
                        // R3
                        chk(out_data == pat(src, seed), "R3 out_data",
                            int'(out_data), int'(pat(src, seed)));
                        k++;
                    end
                    if (p == s) stat_i = i;
                    i++;
                end
            end
        end
        if (!fin) chk(1'b0, "R7 transfer did not finish", i, tot);
        in_valid = 1'b0;
        start = 1'b0;
    endtask

    // watchdog
    initial begin
        #900000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(stat_valid == 1'b0, "R1 stat_valid", int'(stat_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(err == 1'b0, "R1 err", int'(err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R7: idle block takes nothing before start
        in_valid = 1'b1;
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R7 idle before start", int'(in_ready), 0);
        in_valid = 1'b0;

        // R8: zero spare size
        @(negedge clk);
        cfg_spare_sz = '0;
        cfg_chunks = CNT_W'(2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b1;
        #1;
        chk(err == 1'b1, "R8 err zero size", int'(err), 1);
        chk(in_ready == 1'b0, "R8 no accept zero size", int'(in_ready), 0);
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R8 still no accept", int'(in_ready), 0);
        // R8: zero chunk count
        cfg_spare_sz = SPARE_W'(3);
        cfg_chunks = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(err == 1'b1, "R8 err zero count", int'(err), 1);
        chk(in_ready == 1'b0, "R8 no accept zero count", int'(in_ready), 0);
        in_valid = 1'b0;

        // R9: start pulse during a transfer is ignored (also clears err, R8)
        run_xfer(3, 2, 0, 99, 1'b1);
        // R8
        chk(err == 1'b0, "R8 err cleared", int'(err), 0);

        for (int s = 1; s <= 6; s++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int m = 0; m < 3; m++) begin
                    run_xfer(s, n, m, s * 16 + n * 4 + m, 1'b0);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule